// File: doc/BRIEF.md
# Serial Audio Input Deserializer

The block takes a stereo serial audio stream made of a bit clock, a word-select (LR) clock and one data line, and turns it into parallel samples in the system clock domain. The bit clock runs at 64 times the sample rate, so each LR half-period holds 32 bit periods. Each word is two's complement, sent MSB first, and rear packed: its LSB is the last bit before the LR clock changes level.

All three serial lines are brought into the system clock through two-flop synchronisers, and edges are detected there. A bit is taken on each falling bit-clock edge. When the LR clock changes level, the last 32 bits form the finished word. The LR level that framed that word, combined with a polarity input, decides whether it goes to the left or the right holding register. Before it is stored, the word is normalised to a 24-bit sample according to the word-length select. Once both holding registers have been refreshed, a one-cycle pair strobe marks a matched stereo sample.

Top module: `serial_audio_rx`

## Requirements
- R1: A data bit is taken on each falling edge of the bit clock. The word is the bits shifted in before an LR level change, with the last bit as its LSB.
- R2: With word-length select 2'b01 (16-bit), the stored sample is the last 16 bits followed by 8 zero bits.
- R3: With word-length select 2'b11 (20-bit), the stored sample is the last 20 bits followed by 4 zero bits.
- R4: With word-length select 2'b10 (24-bit), the stored sample is the last 24 bits, unchanged.
- R5: With word-length select 2'b00 (32-bit), the stored sample is the upper 24 of the last 32 bits. The low 8 bits are dropped and no rounding is applied.
- R6: With the polarity input at 1, a word framed by a high LR clock goes to the left output and one framed by a low LR clock goes to the right output.
- R7: With the polarity input at 0, a word framed by a low LR clock goes to the left output and one framed by a high LR clock goes to the right output.
- R8: The pair strobe is high for exactly one cycle, in the cycle after the capture that completes a left and right update since the previous strobe. It is the same cycle in which the second sample appears on its output.
- R9: While reset is high and in the first cycle after it, both sample outputs are zero and the pair strobe is low.
- R10: A sample output keeps its value until a new word for that channel is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock (64 x sample rate) |
| word_sel | input | 1 | LR word clock |
| ser_data | input | 1 | Serial audio data |
| len_sel | input | 2 | Word length: 00=32, 01=16, 10=24, 11=20 |
| lr_polarity | input | 1 | 1: LR high is left; 0: LR low is left |
| left_out | output | 24 | Latest normalised left sample |
| right_out | output | 24 | Latest normalised right sample |
| pair_valid | output | 1 | One-cycle strobe when both channels are refreshed |

## Verification
Two events can fall in the same cycle: the capture of the second channel's word, which writes its holding register, and the pair strobe together with the clearing of the refresh flags. The bench sends a left half-frame, a right half-frame and then a further left half-frame. The level change that starts the last half completes the pair. The bench latches both outputs in the cycle the strobe is seen and compares them with the expected normalised words. This shows that the strobe is not issued one cycle early with a stale right sample. A later lone left capture must then change only the left output and leave the strobe count unchanged.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam int FRAME_W  = 32;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    WL_32 = 2'b00,
    WL_16 = 2'b01,
    WL_24 = 2'b10,
    WL_20 = 2'b11
  } wlen_e;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sarx_shift.sv
module sarx_shift
  import sarx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bck_s,
  input  logic               lr_s,
  input  logic               din_s,
  output logic [FRAME_W-1:0] word,
  output logic               word_lr,
  output logic               word_stb
);
  logic               bck_q, lr_q;
  logic [FRAME_W-1:0] sr;
  logic               bck_fall, lr_flip;

  assign bck_fall = bck_q & ~bck_s;
  assign lr_flip  = lr_q ^ lr_s;

  // edge-history flops follow the inputs even in reset, so no false edge at release
  always_ff @(posedge clk) begin
    bck_q <= bck_s;
    lr_q  <= lr_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      word     <= '0;
      word_lr  <= 1'b0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (bck_fall) sr <= {sr[FRAME_W-2:0], din_s};
      if (lr_flip) begin
        word     <= sr;
        word_lr  <= lr_q;
        word_stb <= 1'b1;
      end
    end
  end

  // R1: a captured word is never announced in two consecutive cycles
  p_stb_single_r1: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);
endmodule

// File: rtl/sarx_norm.sv
module sarx_norm
  import sarx_pkg::*;
(
  input  wlen_e               wlen,
  input  logic [FRAME_W-1:0]  word,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int PAD16 = SAMPLE_W - 16;
  localparam int PAD20 = SAMPLE_W - 20;

  always_comb begin
    unique case (wlen)
      WL_16:   sample = {word[15:0], {PAD16{1'b0}}};
      WL_20:   sample = {word[19:0], {PAD20{1'b0}}};
      WL_24:   sample = word[SAMPLE_W-1:0];
      default: sample = word[FRAME_W-1 -: SAMPLE_W];
    endcase
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_clk,
  input  logic                word_sel,
  input  logic                ser_data,
  input  logic [1:0]          len_sel,
  input  logic                lr_polarity,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                pair_valid
);
  logic [2:0]          raw_in, syn_in;
  logic [FRAME_W-1:0]  word;
  logic                word_lr, word_stb;
  logic [SAMPLE_W-1:0] sample;
  logic                is_left, got_l, got_r, got_l_nx, got_r_nx, both;

  assign raw_in = {bit_clk, word_sel, ser_data};

  sarx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_in),
    .q   (syn_in)
  );

  sarx_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .bck_s    (syn_in[2]),
    .lr_s     (syn_in[1]),
    .din_s    (syn_in[0]),
    .word     (word),
    .word_lr  (word_lr),
    .word_stb (word_stb)
  );

  sarx_norm u_norm (
    .wlen   (wlen_e'(len_sel)),
    .word   (word),
    .sample (sample)
  );

  assign is_left  = (word_lr == lr_polarity);
  assign got_l_nx = got_l | (word_stb & is_left);
  assign got_r_nx = got_r | (word_stb & ~is_left);
  assign both     = got_l_nx & got_r_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_out   <= '0;
      right_out  <= '0;
      got_l      <= 1'b0;
      got_r      <= 1'b0;
      pair_valid <= 1'b0;
    end else begin
      if (word_stb && is_left)  left_out  <= sample;
      if (word_stb && !is_left) right_out <= sample;
      got_l      <= both ? 1'b0 : got_l_nx;
      got_r      <= both ? 1'b0 : got_r_nx;
      pair_valid <= both;
    end
  end

  // R8: strobe lasts one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);
  // R8: strobe only follows a word capture
  p_pair_after_capture_r8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $past(word_stb));
  // R10: left sample holds without a left capture
  p_hold_left_r10: assert property (@(posedge clk) disable iff (rst)
    !(word_stb && is_left) |=> $stable(left_out));
  // R10: right sample holds without a right capture
  p_hold_right_r10: assert property (@(posedge clk) disable iff (rst)
    !(word_stb && !is_left) |=> $stable(right_out));
  // R9: cleared state right after reset
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (!pair_valid && left_out == '0 && right_out == '0));
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b0, lrc = 1'b0, din = 1'b0;
  logic [1:0]  len = 2'b01;
  logic        pol = 1'b1;
  logic [23:0] lo, ro;
  logic        pv;

  int errors = 0, checks = 0, pv_cnt = 0;
  logic [23:0] cap_l, cap_r;
  bit done = 0;

  always #10 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .bit_clk(bck), .word_sel(lrc), .ser_data(din),
    .len_sel(len), .lr_polarity(pol), .left_out(lo), .right_out(ro),
    .pair_valid(pv)
  );

  always @(negedge clk) if (pv) begin
    pv_cnt++;
    cap_l = lo;
    cap_r = ro;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] norm(logic [1:0] l, logic [31:0] w);
    case (l)
      2'b01:   return {w[15:0], 8'h00};
      2'b11:   return {w[19:0], 4'h0};
      2'b10:   return w[23:0];
      default: return w[31:8];
    endcase
  endfunction

  function automatic int nbits(logic [1:0] l);
    case (l)
      2'b01: return 16;
      2'b11: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  // one half-frame of 32 bit periods; data and LR change at the rising edge
  task automatic send_half(logic level, logic [31:0] w, int n);
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      bck = 1'b1;
      if (p == 0) lrc = level;
      din = (p >= 32 - n) ? w[31-p] : 1'b1;
      repeat (4) @(negedge clk);
      bck = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_reset(logic idle_lr);
    @(negedge clk);
    rst = 1'b1; bck = 1'b0; din = 1'b0; lrc = idle_lr;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    pv_cnt = 0;
  endtask

  task automatic run_pair(string tag, logic p, logic [1:0] l,
                          logic [31:0] lw, logic [31:0] rw, logic [31:0] nxt);
    logic lv;
    pol = p; len = l;
    lv = p;
    do_reset(lv);
    send_half(lv, lw, nbits(l));
    send_half(~lv, rw, nbits(l));
    send_half(lv, nxt, nbits(l));
    repeat (8) @(negedge clk);
    check({tag, " pair count"}, pv_cnt, 1);
    check({tag, " left"},  {8'h0, cap_l}, {8'h0, norm(l, lw)});
    check({tag, " right"}, {8'h0, cap_r}, {8'h0, norm(l, rw)});
  endtask

  task automatic test_reset();
    pol = 1'b1; len = 2'b01;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 left at reset",  {8'h0, lo}, 0);
    check("R9 right at reset", {8'h0, ro}, 0);
    check("R9 strobe at reset", {31'h0, pv}, 0);
  endtask

  // R10/R8: a lone left word updates left only, no new strobe
  task automatic test_lone_left();
    logic [23:0] r_before;
    r_before = ro;
    send_half(~pol, 32'h0000_0000, 32);
    repeat (8) @(negedge clk);
    check("R8 no strobe on lone word", pv_cnt, 1);
    check("R10 left refreshed", {8'h0, lo}, {8'h0, norm(len, 32'h1357_9BDF)});
    check("R10 right held", {8'h0, ro}, {8'h0, r_before});
  endtask

  initial begin
    test_reset();
    run_pair("R2 R1 R6 16b", 1'b1, 2'b01, 32'h0000_8001, 32'h0000_7FFF, 32'h0);
    run_pair("R3 R6 20b",    1'b1, 2'b11, 32'h000A_5A5A, 32'h0000_0001, 32'h0);
    run_pair("R4 R7 24b",    1'b0, 2'b10, 32'h0012_3456, 32'h00FE_DCBA, 32'h0);
    run_pair("R5 R6 32b",    1'b1, 2'b00, 32'hDEAD_BEEF, 32'h0000_00FF, 32'h1357_9BDF);
    test_lone_left();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule